// File: doc/BRIEF.md
# Deskew Delay Loop Controller

This block closes the digital control loop of a clock and data recovery path in which the incoming data, not the clock, is moved in time. A shared global clock stays untouched. A bang-bang phase detector upstream reports, once per clock, whether the data edge came early (lead) or late (lag). The controller turns those reports into a delay-line control word.

The reports are not fed through a loop filter. A signed confidence counter accumulates them instead. Only when the evidence reaches a fixed threshold in one direction does the counter issue a single step request. A code stepper turns each request into a move of one position along a combined delay index. That index has two parts. The coarse part sets how many buffer stages of the chain are enabled. The fine part sets how many load units are switched onto the line.

The whole range covers about one unit interval. The loop is meant for short bursts and does not follow a frequency offset. A burst-start pulse re-centres the delay and discards any evidence that has built up.

Top module: `deskew_loop_ctrl`

## Requirements
- R1: After reset, coarse_code is 2**(COARSE_W-1) (8 by default), fine_code is 0 and range_limit is 0. The delay index is coarse_code*2**FINE_W + fine_code, which is 64 by default.
- R2: With a cleared counter, CONF_LIMIT (8) cycles of lag alone, each with lead low, raise the delay index by exactly one. The update lands two clock edges after the last lag cycle. CONF_LIMIT-1 such cycles leave the index unchanged.
- R3: CONF_LIMIT cycles of lead alone, each with lag low, lower the delay index by exactly one.
- R4: A cycle with both lead and lag high, or with both low, leaves the confidence counter unchanged.
- R5: The counter is signed and counts lag up and lead down. It returns to zero each time it issues a request, so 2*CONF_LIMIT lag cycles give two steps, and lag and lead cycles in equal number cancel.
- R6: An up step from fine_code 7 sets fine_code to 0 and raises coarse_code by one. A down step from fine_code 0 sets fine_code to 7 and lowers coarse_code by one.
- R7: At the top of the range (coarse_code 15, fine_code 7), an up request leaves both codes unchanged and sets range_limit to 1. At the bottom (both codes 0), a down request does the same.
- R8: range_limit stays at 1 until the next step that is actually applied, which clears it.
- R9: burst_start high for one cycle returns the codes to the reset values of R1, clears range_limit and clears the confidence counter, so lag cycles counted before it are lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock, shared with the data path |
| rst_n | input | 1 | Synchronous reset, active low |
| burst_start | input | 1 | Re-centre the delay and clear the evidence |
| lead | input | 1 | Data edge early relative to the clock this cycle |
| lag | input | 1 | Data edge late relative to the clock this cycle |
| coarse_code | output | COARSE_W (4) | Number of enabled delay stages |
| fine_code | output | FINE_W (3) | Number of switched load units |
| range_limit | output | 1 | A step request was dropped at an end of the range |

## Verification
The properties assume that lead, lag and burst_start are synchronous to clk and settled before each rising edge. They also assume reset is held for at least one edge, so the counter and the codes start from defined values. The bench changes every input only on the falling edge and reads the codes after the two-edge request pipeline has drained. The stimulus walks the index through every position from the bottom to the top of the range, which exercises each fine rollover and both range ends.

// File: rtl/deskew_pkg.sv
// Package: types shared by the deskew loop controller.
// Assumes: it is compiled before every module that imports it.
package deskew_pkg;
    // Step request passed from the confidence filter to the code stepper.
    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_UP   = 2'd1,
        REQ_DN   = 2'd2
    } step_req_t;
endpackage

// File: rtl/deskew_conf_filter.sv
// Module: deskew_conf_filter
// Accumulates lag (+1) and lead (-1) in a signed counter. On reaching
// +CONF_LIMIT or -CONF_LIMIT it issues a one-cycle request and returns to zero.
// Assumes: lead/lag are synchronous to clk; clear has priority over counting.
module deskew_conf_filter
    import deskew_pkg::*;
#(
    parameter int CONF_LIMIT = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clear,
    input  logic      lead,
    input  logic      lag,
    output step_req_t req
);
    localparam int CNT_W = $clog2(CONF_LIMIT) + 2;
    localparam logic signed [CNT_W-1:0] POS = CNT_W'(CONF_LIMIT);
    localparam logic signed [CNT_W-1:0] NEG = -POS;
    localparam logic signed [CNT_W-1:0] ONE = CNT_W'(1);

    logic signed [CNT_W-1:0] cnt;
    logic signed [CNT_W-1:0] cnt_nx;

    // Next count: a lone lag counts up, a lone lead counts down, otherwise hold.
    always_comb begin
        cnt_nx = cnt;
        if (lag && !lead)
            cnt_nx = cnt + ONE;
        else if (lead && !lag)
            cnt_nx = cnt - ONE;
    end

    // Counter register and request output; a threshold hit emits and re-zeros.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
            req <= REQ_NONE;
        end else if (cnt_nx == POS) begin
            cnt <= '0;
            req <= REQ_UP;
        end else if (cnt_nx == NEG) begin
            cnt <= '0;
            req <= REQ_DN;
        end else begin
            cnt <= cnt_nx;
            req <= REQ_NONE;
        end
    end

    // R5: the stored count always stays strictly inside the thresholds.
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt < POS) && (cnt > NEG));

    // R5: a request is always issued with the counter back at zero.
    assert_emit_rezero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req != REQ_NONE) |-> (cnt == '0));

    // R9: a clear leaves the counter at zero with no request pending.
    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0) && (req == REQ_NONE));
endmodule

// File: rtl/deskew_delay_code.sv
// Module: deskew_delay_code
// Holds the coarse stage-enable code and the fine load code. It moves their
// combined index by one per request, rolling fine into coarse. Requests that
// would leave the range are dropped and flagged.
// Assumes: at most one request per cycle; restart has priority over requests.
module deskew_delay_code
    import deskew_pkg::*;
#(
    parameter int COARSE_W = 4,
    parameter int FINE_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    input  step_req_t           req,
    output logic [COARSE_W-1:0] coarse,
    output logic [FINE_W-1:0]   fine,
    output logic                range_limit
);
    localparam int IDX_W = COARSE_W + FINE_W;
    localparam logic [COARSE_W-1:0] C_MAX = '1;
    localparam logic [COARSE_W-1:0] C_MID = COARSE_W'(1 << (COARSE_W - 1));
    localparam logic [FINE_W-1:0]   F_MAX = '1;

    logic at_top;
    logic at_bot;
    logic [IDX_W-1:0] idx;

    // Range-end detection on the combined code.
    always_comb begin
        at_top = (coarse == C_MAX) && (fine == F_MAX);
        at_bot = (coarse == '0) && (fine == '0);
        idx    = {coarse, fine};
    end

    // Code register: re-centre, step with fine-to-coarse carry, or drop at an end.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            coarse      <= C_MID;
            fine        <= '0;
            range_limit <= 1'b0;
        end else if (req == REQ_UP) begin
            if (at_top) begin
                range_limit <= 1'b1;
            end else begin
                range_limit <= 1'b0;
                if (fine == F_MAX) begin
                    fine   <= '0;
                    coarse <= coarse + 1'b1;
                end else begin
                    fine <= fine + 1'b1;
                end
            end
        end else if (req == REQ_DN) begin
            if (at_bot) begin
                range_limit <= 1'b1;
            end else begin
                range_limit <= 1'b0;
                if (fine == '0) begin
                    fine   <= F_MAX;
                    coarse <= coarse - 1'b1;
                end else begin
                    fine <= fine - 1'b1;
                end
            end
        end
    end

    // R6: an applied up request advances the combined index by exactly one.
    assert_step_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req == REQ_UP) && !at_top && !restart |=> ($past(idx) == idx - IDX_W'(1)));

    // R6: an applied down request retreats the combined index by exactly one.
    assert_step_dn_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req == REQ_DN) && !at_bot && !restart |=> ($past(idx) == idx + IDX_W'(1)));

    // R7: a request past either end leaves the codes alone and raises the flag.
    assert_hold_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (((req == REQ_UP) && at_top) || ((req == REQ_DN) && at_bot)) && !restart
        |=> $stable(idx) && range_limit);

    // R9: restart returns the codes to mid-range with the flag clear.
    assert_restart_mid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (coarse == C_MID) && (fine == '0) && !range_limit);
endmodule

// File: rtl/deskew_loop_ctrl.sv
// Module: deskew_loop_ctrl (top)
// Digital control loop of a data-deskew recovery path: a confidence filter
// on the phase detector's lead/lag flags, feeding a coarse/fine code stepper.
// Assumes: inputs synchronous to clk; reset held for at least one edge.
module deskew_loop_ctrl
    import deskew_pkg::*;
#(
    parameter int CONF_LIMIT = 8,
    parameter int COARSE_W   = 4,
    parameter int FINE_W     = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                burst_start,
    input  logic                lead,
    input  logic                lag,
    output logic [COARSE_W-1:0] coarse_code,
    output logic [FINE_W-1:0]   fine_code,
    output logic                range_limit
);
    step_req_t step_req;

    // Evidence filter: lead/lag flags in, single step requests out.
    deskew_conf_filter #(
        .CONF_LIMIT (CONF_LIMIT)
    ) u_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (burst_start),
        .lead  (lead),
        .lag   (lag),
        .req   (step_req)
    );

    // Code stepper: requests in, stage-enable and load codes out.
    deskew_delay_code #(
        .COARSE_W (COARSE_W),
        .FINE_W   (FINE_W)
    ) u_code (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (burst_start),
        .req         (step_req),
        .coarse      (coarse_code),
        .fine        (fine_code),
        .range_limit (range_limit)
    );
endmodule

// File: tb/deskew_loop_ctrl_bench.sv
`timescale 1ns/1ps
// Bench: walks the delay index across its whole range and checks every
// position. Expected codes come from an arithmetic tally of the requirements.
module deskew_loop_ctrl_bench;
    localparam int N    = 8;
    localparam int CW   = 4;
    localparam int FW   = 3;
    localparam int IMAX = (1 << (CW + FW)) - 1;
    localparam int IMID = 1 << (CW + FW - 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic burst_start = 1'b0;
    logic lead = 1'b0;
    logic lag = 1'b0;
    logic [CW-1:0] coarse_code;
    logic [FW-1:0] fine_code;
    logic range_limit;

    int checks = 0;
    int fails  = 0;
    int m_cnt  = 0;
    int m_idx  = IMID;
    bit m_lim  = 1'b0;

    always #2.5 clk = ~clk;

    deskew_loop_ctrl #(.CONF_LIMIT(N), .COARSE_W(CW), .FINE_W(FW)) u_deskew_loop_ctrl (
        .clk(clk), .rst_n(rst_n), .burst_start(burst_start), .lead(lead), .lag(lag),
        .coarse_code(coarse_code), .fine_code(fine_code), .range_limit(range_limit));

    // One clock of stimulus, driven at the falling edge; the tally follows the requirements.
    task automatic tick(input bit ld, input bit lg, input bit bs);
        @(negedge clk);
        lead = ld; lag = lg; burst_start = bs;
        if (bs) begin
            m_cnt = 0; m_idx = IMID; m_lim = 1'b0;
        end else begin
            if (lg && !ld) m_cnt++;
            else if (ld && !lg) m_cnt--;
            if (m_cnt == N) begin
                m_cnt = 0;
                if (m_idx == IMAX) m_lim = 1'b1; else begin m_idx++; m_lim = 1'b0; end
            end else if (m_cnt == -N) begin
                m_cnt = 0;
                if (m_idx == 0) m_lim = 1'b1; else begin m_idx--; m_lim = 1'b0; end
            end
        end
    endtask

    task automatic run(input bit ld, input bit lg, input int n);
        for (int i = 0; i < n; i++) tick(ld, lg, 1'b0);
    endtask

    // Drain the two-edge request pipeline, then compare at the falling edge.
    task automatic check(input string req);
        int got;
        run(1'b0, 1'b0, 3);
        @(negedge clk);
        got = int'({coarse_code, fine_code});
        checks++;
        if (got != m_idx || range_limit != m_lim) begin
            fails++;
            $display("FAIL %s: index=%0d (coarse=%0d fine=%0d) limit=%0d, expected index=%0d (coarse=%0d fine=%0d) limit=%0d",
                     req, got, coarse_code, fine_code, range_limit,
                     m_idx, m_idx >> FW, m_idx % (1 << FW), m_lim);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #500000;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset state");

        run(1'b0, 1'b1, N - 1);  check("R2 one lag short of the threshold");
        run(1'b0, 1'b1, 1);      check("R2 threshold reached, one up step");
        run(1'b1, 1'b0, N);      check("R3 lead threshold, one down step");

        run(1'b0, 1'b1, N - 1);
        run(1'b1, 1'b1, 5);
        run(1'b0, 1'b0, 5);      check("R4 both-high and both-low cycles hold the count");
        run(1'b0, 1'b1, 1);      check("R4 count resumed after hold cycles");

        run(1'b0, 1'b1, 2 * N);  check("R5 twice the threshold gives two steps");
        run(1'b0, 1'b1, N - 1);
        run(1'b1, 1'b0, N - 1);  check("R5 equal lag and lead cancel");
        run(1'b1, 1'b0, N);      check("R5 counter re-zeroed before lead run");

        tick(1'b0, 1'b0, 1'b1);  check("R9 burst start re-centres");
        run(1'b0, 1'b1, N - 1);
        tick(1'b0, 1'b0, 1'b1);
        run(1'b0, 1'b1, N - 1);  check("R9 evidence before burst start discarded");
        tick(1'b0, 1'b0, 1'b1);

        // R6/R7: step through every index up to the top, then past it.
        for (int s = IMID; s < IMAX; s++) begin
            run(1'b0, 1'b1, N);
            check("R6 up walk with fine rollover");
        end
        run(1'b0, 1'b1, N);      check("R7 up request dropped at top");
        run(1'b0, 1'b1, N);      check("R7 top still held, flag set");
        run(1'b1, 1'b0, N);      check("R8 applied down step clears flag");

        // R6/R7: from the top, walk down through every index to the bottom.
        run(1'b0, 1'b1, N);
        for (int s = IMAX; s > 0; s--) begin
            run(1'b1, 1'b0, N);
            check("R6 down walk with fine borrow");
        end
        run(1'b1, 1'b0, N);      check("R7 down request dropped at bottom");
        run(1'b0, 1'b1, N);      check("R8 applied up step clears flag");
        run(1'b1, 1'b0, 2 * N);  check("R7 bottom reached again, flag set");
        tick(1'b0, 1'b0, 1'b1);  check("R9 burst start clears flag and re-centres");

        rst_n = 1'b0;
        run(1'b0, 1'b1, 2);
        rst_n = 1'b1;
        m_cnt = 0; m_idx = IMID; m_lim = 1'b0;
        check("R1 reset restores mid-range");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule